// File: doc/BRIEF.md
# Two-Compare Square-Wave Timer

This block is an up-counting timer that makes a square wave whose period and high/low split are both set by software. Two compare values are held in registers. When the count reaches the lower value (the toggle point), the output level flips and counting goes on. When the count reaches the upper value (the period point), the output flips again and the count returns to zero. The period is therefore the period value plus one count ticks. The toggle value sets where the level changes inside that period.

Software programs the block through a small word-wide register port. It chooses the level the output takes when counting starts. Each compare point has its own sticky status flag and its own enable bit. The two enabled flags are combined into one active-low interrupt request. A flag is cleared by writing 0 to its status bit.

Counting is paced by a one-cycle tick input, so the block does not care where the tick comes from. The tick may be the system clock itself or a divided or external clock that has already been turned into a pulse.

Top module: `twc_pulse_gen`

## Requirements
- R1: While the run bit (control register at address 0, bit 0) is 1, the counter rises by exactly one on every clock whose `cnt_tick` is high. When the tick is low or run is 0, the counter holds its value. The count reads back at address 4, and the field is 24 bits wide.
- R2: On a tick where the count equals the toggle value (address 1, bits 23:0) and does not equal the period value, `pwm_out` inverts one clock later and the count keeps rising.
- R3: On a tick where the count equals the period value (address 2, bits 23:0), `pwm_out` inverts and the count becomes 0 one clock later. If both compare values are equal, only this period action takes place.
- R4: A write to address 0 that sets run to 1 while run is 0 clears the count to 0. The same write loads `pwm_out` with bit 1 of the written data. A write that keeps run at 1 does not restart the count.
- R5: A toggle match sets status bit 0, and a period match sets status bit 1. The status register is at address 3. These flags are set whatever the enable bits hold.
- R6: `irq_n` is low exactly when (status bit 0 AND control bit 2) OR (status bit 1 AND control bit 3) is true. Otherwise it is high.
- R7: Writing 0 to a status bit clears that flag. Writing 1 to it leaves the flag unchanged.
- R8: If a match sets a flag on the same clock that software clears it, the flag ends up set.
- R9: After reset, every register reads 0, `pwm_out` is 0 and `irq_n` is 1. The compare registers read back what was written, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register address for both read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cnt_tick | input | 1 | Count tick, high for one clock per count step |
| pwm_out | output | 1 | Square-wave output |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
Every result of a tick or a write is due exactly one clock after the edge that samples it. This covers the count, the output level and the status flags. `irq_n` and `bus_rdata` follow those registers with no further delay. The bench changes its inputs just after a rising edge. A behavioural model advances on that same edge, and all outputs are compared at the following falling edge, when both sides have settled. Directed checks place a software clear on the exact edge of a period match, and start a run with each output level, so that the ordering cases are tested at the clock where they occur.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam int TWC_ADDR_CTRL   = 0;
  localparam int TWC_ADDR_TOGGLE = 1;
  localparam int TWC_ADDR_PERIOD = 2;
  localparam int TWC_ADDR_STATUS = 3;
  localparam int TWC_ADDR_COUNT  = 4;

  localparam int TWC_BIT_RUN   = 0;
  localparam int TWC_BIT_LEVEL = 1;
  localparam int TWC_BIT_EN_T  = 2;
  localparam int TWC_BIT_EN_P  = 3;

  localparam int TWC_NUM_CMP = 2;
  localparam int TWC_IDX_T   = 0;
  localparam int TWC_IDX_P   = 1;

  typedef struct packed {
    logic en_p;
    logic en_t;
    logic level;
    logic run;
  } twc_ctrl_t;
endpackage

// File: rtl/twc_regs.sv
module twc_regs
  import twc_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [CNT_W-1:0]       count,
  input  logic [TWC_NUM_CMP-1:0] flags,
  output twc_ctrl_t              ctrl,
  output logic [CNT_W-1:0]       cmp_toggle,
  output logic [CNT_W-1:0]       cmp_period,
  output logic                   start,
  output logic                   start_level,
  output logic [TWC_NUM_CMP-1:0] sw_clr
);
  localparam int PAD_CNT = DATA_W - CNT_W;
  localparam int PAD_CTL = DATA_W - $bits(twc_ctrl_t);
  localparam int PAD_FLG = DATA_W - TWC_NUM_CMP;

  logic sel_ctrl, sel_tog, sel_per, sel_stat;
  twc_ctrl_t ctrl_d;
  logic [CNT_W-1:0] tog_d, per_d;
  logic unused_wdata;

  assign sel_ctrl = bus_wr && (bus_addr == ADDR_W'(TWC_ADDR_CTRL));
  assign sel_tog  = bus_wr && (bus_addr == ADDR_W'(TWC_ADDR_TOGGLE));
  assign sel_per  = bus_wr && (bus_addr == ADDR_W'(TWC_ADDR_PERIOD));
  assign sel_stat = bus_wr && (bus_addr == ADDR_W'(TWC_ADDR_STATUS));
  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

  assign start       = sel_ctrl && bus_wdata[TWC_BIT_RUN] && !ctrl.run;
  assign start_level = bus_wdata[TWC_BIT_LEVEL];

  generate
    for (genvar i = 0; i < TWC_NUM_CMP; i++) begin : g_clr
      assign sw_clr[i] = sel_stat && !bus_wdata[i];
    end
  endgenerate

  always_comb begin
    ctrl_d = ctrl;
    tog_d  = cmp_toggle;
    per_d  = cmp_period;
    if (sel_ctrl) begin
      ctrl_d.run   = bus_wdata[TWC_BIT_RUN];
      ctrl_d.level = bus_wdata[TWC_BIT_LEVEL];
      ctrl_d.en_t  = bus_wdata[TWC_BIT_EN_T];
      ctrl_d.en_p  = bus_wdata[TWC_BIT_EN_P];
    end
    if (sel_tog) tog_d = bus_wdata[CNT_W-1:0];
    if (sel_per) per_d = bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl       <= '0;
      cmp_toggle <= '0;
      cmp_period <= '0;
    end else begin
      if (sel_ctrl) ctrl       <= ctrl_d;
      if (sel_tog)  cmp_toggle <= tog_d;
      if (sel_per)  cmp_period <= per_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(TWC_ADDR_CTRL):   bus_rdata = {{PAD_CTL{1'b0}}, ctrl};
      ADDR_W'(TWC_ADDR_TOGGLE): bus_rdata = {{PAD_CNT{1'b0}}, cmp_toggle};
      ADDR_W'(TWC_ADDR_PERIOD): bus_rdata = {{PAD_CNT{1'b0}}, cmp_period};
      ADDR_W'(TWC_ADDR_STATUS): bus_rdata = {{PAD_FLG{1'b0}}, flags};
      ADDR_W'(TWC_ADDR_COUNT):  bus_rdata = {{PAD_CNT{1'b0}}, count};
      default:                  bus_rdata = '0;
    endcase
  end

  // R4: a start strobe only appears while stopped, and run is set afterwards
  assert_start_sets_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ctrl.run);
endmodule

// File: rtl/twc_core.sv
module twc_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             start,
  input  logic             start_level,
  input  logic [CNT_W-1:0] cmp_toggle,
  input  logic [CNT_W-1:0] cmp_period,
  output logic [CNT_W-1:0] count,
  output logic             wave,
  output logic             hit_toggle,
  output logic             hit_period
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ff_q, ff_d;
  logic             step, eq_t, eq_p, clk_en;

  assign step       = run && tick && !start;
  assign eq_t       = (cnt_q == cmp_toggle);
  assign eq_p       = (cnt_q == cmp_period);
  assign hit_period = step && eq_p;
  assign hit_toggle = step && eq_t && !eq_p;
  assign clk_en     = start || step;

  always_comb begin
    cnt_d = cnt_q;
    ff_d  = ff_q;
    if (start) begin
      cnt_d = '0;
      ff_d  = start_level;
    end else if (hit_period) begin
      cnt_d = '0;
      ff_d  = !ff_q;
    end else if (step) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (hit_toggle) ff_d = !ff_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ff_q  <= 1'b0;
    end else if (clk_en) begin
      cnt_q <= cnt_d;
      ff_q  <= ff_d;
    end
  end

  assign count = cnt_q;
  assign wave  = ff_q;

  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(run && tick)) |=> ($stable(count) && $stable(wave)));
  assert_toggle_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_toggle |=> (wave != $past(wave)) && (count == $past(count) + CNT_W'(1)));
  assert_period_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_period |=> (count == '0) && (wave != $past(wave)));
  assert_start_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (count == '0) && (wave == $past(start_level)));
endmodule

// File: rtl/twc_flags.sv
module twc_flags #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] hw_set,
  input  logic [NUM-1:0] sw_clr,
  input  logic [NUM-1:0] enable,
  output logic [NUM-1:0] flags,
  output logic           irq_n
);
  logic [NUM-1:0] flag_q, flag_d;

  generate
    for (genvar i = 0; i < NUM; i++) begin : g_flag
      assign flag_d[i] = hw_set[i] || (flag_q[i] && !sw_clr[i]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q[i] <= 1'b0;
        else        flag_q[i] <= flag_d[i];
      end

      assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set[i] |=> flags[i]);
      assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hw_set[i] && !sw_clr[i]) |=> (flags[i] == $past(flags[i])));
    end
  endgenerate

  assign flags = flag_q;
  assign irq_n = !(|(flag_q & enable));
endmodule

// File: rtl/twc_pulse_gen.sv
module twc_pulse_gen
  import twc_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cnt_tick,
  output logic              pwm_out,
  output logic              irq_n
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  twc_ctrl_t              ctrl;
  logic [CNT_W-1:0]       cmp_toggle, cmp_period, count;
  logic                   start, start_level, hit_t, hit_p;
  logic [TWC_NUM_CMP-1:0] sw_clr, hw_set, flags, enables;

  assign hw_set[TWC_IDX_T]  = hit_t;
  assign hw_set[TWC_IDX_P]  = hit_p;
  assign enables[TWC_IDX_T] = ctrl.en_t;
  assign enables[TWC_IDX_P] = ctrl.en_p;

  twc_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count(count), .flags(flags), .ctrl(ctrl),
    .cmp_toggle(cmp_toggle), .cmp_period(cmp_period),
    .start(start), .start_level(start_level), .sw_clr(sw_clr)
  );

  twc_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_int_n), .run(ctrl.run), .tick(cnt_tick),
    .start(start), .start_level(start_level),
    .cmp_toggle(cmp_toggle), .cmp_period(cmp_period),
    .count(count), .wave(pwm_out), .hit_toggle(hit_t), .hit_period(hit_p)
  );

  twc_flags #(.NUM(TWC_NUM_CMP)) u_flags (
    .clk(clk), .rst_n(rst_int_n), .hw_set(hw_set), .sw_clr(sw_clr),
    .enable(enables), .flags(flags), .irq_n(irq_n)
  );
endmodule

// File: tb/twc_pulse_gen_tb.sv
module twc_pulse_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        cnt_tick = 1'b0;
  logic        pwm_out, irq_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit live = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  twc_pulse_gen u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_tick(cnt_tick),
    .pwm_out(pwm_out), .irq_n(irq_n)
  );

  // behavioural reference
  logic [23:0] m_cnt, m_tog, m_per;
  logic m_run, m_lvl, m_et, m_ep, m_ff, m_ft, m_fp;
  logic st, ht, hp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_tog = 0; m_per = 0;
      m_run = 0; m_lvl = 0; m_et = 0; m_ep = 0; m_ff = 0; m_ft = 0; m_fp = 0;
    end else begin
      st = bus_wr && bus_addr == 3'd0 && bus_wdata[0] && !m_run;
      ht = 0; hp = 0;
      if (m_run && cnt_tick && !st) begin
        if (m_cnt == m_per) hp = 1;
        else if (m_cnt == m_tog) ht = 1;
      end
      if (st) begin m_cnt = 0; m_ff = bus_wdata[1]; end
      else if (hp) begin m_cnt = 0; m_ff = ~m_ff; end
      else if (m_run && cnt_tick) begin
        m_cnt = m_cnt + 24'd1;
        if (ht) m_ff = ~m_ff;
      end
      m_ft = ht | (m_ft & ~(bus_wr && bus_addr == 3'd3 && !bus_wdata[0]));
      m_fp = hp | (m_fp & ~(bus_wr && bus_addr == 3'd3 && !bus_wdata[1]));
      if (bus_wr && bus_addr == 3'd0) begin
        m_run = bus_wdata[0]; m_lvl = bus_wdata[1]; m_et = bus_wdata[2]; m_ep = bus_wdata[3];
      end
      if (bus_wr && bus_addr == 3'd1) m_tog = bus_wdata[23:0];
      if (bus_wr && bus_addr == 3'd2) m_per = bus_wdata[23:0];
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: m_read = {28'd0, m_ep, m_et, m_lvl, m_run};
      3'd1: m_read = {8'd0, m_tog};
      3'd2: m_read = {8'd0, m_per};
      3'd3: m_read = {30'd0, m_fp, m_ft};
      3'd4: m_read = {8'd0, m_cnt};
      default: m_read = 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // every-clock comparison at the falling edge
  always @(negedge clk) begin
    cycles++;
    if (live) begin
      chk("R2 R3 pwm_out", {31'd0, pwm_out}, {31'd0, m_ff});
      chk("R6 irq_n", {31'd0, irq_n}, {31'd0, !((m_ft & m_et) | (m_fp & m_ep))});
      chk(bus_addr == 3'd4 ? "R1 count" : (bus_addr == 3'd3 ? "R5 status" : "R9 readback"),
          bus_rdata, m_read(bus_addr));
    end
  end

  task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] d, input logic t);
    @(posedge clk); #1;
    bus_wr = wr; bus_addr = a; bus_wdata = d; cnt_tick = t;
  endtask

  task automatic run_idle(input int n, input int tick_every);
    for (int i = 0; i < n; i++)
      cyc(1'b0, (i % 3 == 0) ? 3'd3 : 3'd4, 32'd0, (i % tick_every) == 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset values
    chk("R9 reset pwm", {31'd0, pwm_out}, 32'd0);
    chk("R9 reset irq", {31'd0, irq_n}, 32'd1);
    bus_addr = 3'd0; #1 chk("R9 reset ctrl", bus_rdata, 32'd0);
    bus_addr = 3'd4; #1 chk("R9 reset count", bus_rdata, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    live = 1'b1;

    cyc(1, 3'd1, 32'hFF00_0003, 0);
    cyc(1, 3'd2, 32'd9, 0);
    cyc(1, 3'd5, 32'hFFFF_FFFF, 0);
    cyc(1, 3'd0, 32'b0101, 0);
    run_idle(40, 1);
    // R6: toggle flag set with its enable -> request low
    @(negedge clk); chk("R6 irq asserted", {31'd0, irq_n}, 32'd0);
    // R7: write 1 keeps flags, write 0 clears
    cyc(1, 3'd3, 32'd3, 0);
    cyc(0, 3'd3, 32'd0, 0);
    @(negedge clk); chk("R7 write one keeps", bus_rdata, 32'd3);
    cyc(1, 3'd3, 32'd0, 0);
    cyc(0, 3'd3, 32'd0, 0);
    @(negedge clk); chk("R7 write zero clears", bus_rdata, 32'd0);
    chk("R7 irq released", {31'd0, irq_n}, 32'd1);
    // sparse ticks, period enable on
    cyc(1, 3'd0, 32'b1101, 0);
    run_idle(45, 3);
    // R4: rewrite with run kept at 1 does not restart
    cyc(1, 3'd0, 32'b1111, 1);
    run_idle(5, 1);
    // stop, hold, restart with level 1
    cyc(1, 3'd0, 32'd0, 0);
    run_idle(6, 1);
    cyc(1, 3'd1, 32'd2, 0);
    cyc(1, 3'd2, 32'd5, 0);
    cyc(1, 3'd3, 32'd0, 0);
    cyc(1, 3'd0, 32'b0011, 1);
    cyc(1, 3'd3, 32'd0, 1);
    @(negedge clk);
    chk("R4 start count", {8'd0, m_cnt}, 32'd0);
    chk("R4 start level", {31'd0, pwm_out}, 32'd1);
    repeat (5) cyc(1, 3'd3, 32'd0, 1);
    cyc(0, 3'd3, 32'd0, 1);
    // R8: period match and clear on the same edge -> period flag set
    @(negedge clk); chk("R8 set beats clear", bus_rdata, 32'd2);
    cyc(0, 3'd4, 32'd0, 0);
    @(negedge clk); chk("R3 count wrapped", bus_rdata, 32'd1);
    // R3: equal compares, only period action
    cyc(1, 3'd0, 32'd0, 0);
    cyc(1, 3'd1, 32'd4, 0);
    cyc(1, 3'd2, 32'd4, 0);
    cyc(1, 3'd3, 32'd0, 0);
    cyc(1, 3'd0, 32'b1101, 0);
    run_idle(30, 2);
    @(negedge clk); chk("R3 equal compares no toggle flag", {31'd0, m_ft}, 32'd0);
    chk("R5 toggle flag untouched", bus_rdata & 32'd1, 32'd0);
    cyc(0, 3'd0, 32'd0, 0);
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule